// File: doc/BRIEF.md
# Step-Sequenced Hardwired Instruction Controller

This block drives the gating and function-select lines of a single-bus processor datapath. A clocked step counter divides each instruction into equal time slots. In every slot the controller raises a set of control lines. Which lines it raises depends on four things: the current step, the class decoded from the instruction opcode, the negative condition flag and whether the current slot is the first one in that step.

Every instruction starts with the same three-slot fetch. The fetch sends the program counter to the address register and starts a read. It increments the program counter through the ALU while memory is busy, and then moves the fetched word into the instruction register. After the fetch, the opcode selects an execution sequence. The sequences are: add a memory operand into a register, jump by the instruction's offset, branch by the offset when the negative flag is set, and treat anything else as a no-operation.

Two kinds of step wait for the memory to report completion, and the counter holds its value while it waits. Raising the end line returns the counter to the first fetch slot on the next clock.

Top module: `hcu_ctrl_unit`

## Requirements
- R1: During reset and in the first slot after it, `step` is 0. Step 0 raises exactly `pc_out`, `mar_in`, `mem_rd`, `y_clr`, `alu_cin`, `alu_add` and `z_in`.
- R2: Step 1 is a memory wait step. In the first cycle of the step it raises exactly `z_out` and `pc_in`. While `mem_done` is low the step holds, and every cycle after the first raises no line at all.
- R3: Step 2 raises exactly `mdr_out` and `ir_in`, and the next cycle is step 3.
- R4: `ir_opcode` is the upper opcode field of the instruction register. It is decoded only from step 3 onward, with 1 = add, 2 = jump, 3 = branch-on-negative, and every other value treated as unrecognised.
- R5: For the add opcode, the execution steps raise the following lines:
  - step 3: `ir_offs_out`, `mar_in`, `mem_rd`
  - step 4: a memory wait step; in its first cycle only, `rf_out` and `y_in`
  - step 5: `mdr_out`, `alu_add`, `z_in`
  - step 6: `z_out`, `rf_in`
  - step 7: `end_op`

  The instruction occupies eight slots when memory answers at once.
- R6: For the jump opcode, the execution steps raise the following lines:
  - step 3: `pc_out`, `y_in`
  - step 4: `ir_offs_out`, `alu_add`, `z_in`
  - step 5: `z_out`, `pc_in`
  - step 6: `end_op`
- R7: For the branch-on-negative opcode, `flag_n` is sampled in step 3 only. If it is 1, the jump sequence of R6 follows. If it is 0, step 3 raises only `end_op`.
- R8: An unrecognised opcode raises only `end_op` in step 3.
- R9: In the cycle after `end_op` is high, `step` is 0.
- R10: At most one of `pc_out`, `z_out`, `mdr_out`, `ir_offs_out` and `rf_out` is high in any cycle.
- R11: `mem_rd` is never high without `mar_in`.
- R12: Outside a holding wait step and outside an end slot, `step` advances by exactly one per clock. `mem_done` has no effect in steps that do not wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_opcode | input | OPC_W | Opcode field of the instruction register |
| flag_n | input | 1 | Negative condition flag |
| mem_done | input | 1 | Memory reports the requested access complete |
| pc_out | output | 1 | Drive program counter onto the bus |
| pc_in | output | 1 | Load program counter from the bus |
| mar_in | output | 1 | Load memory address register |
| mdr_out | output | 1 | Drive memory data register onto the bus |
| ir_in | output | 1 | Load instruction register |
| y_in | output | 1 | Load ALU operand register |
| y_clr | output | 1 | Force ALU operand register to zero |
| z_in | output | 1 | Load ALU result register |
| z_out | output | 1 | Drive ALU result register onto the bus |
| alu_cin | output | 1 | ALU carry-in |
| alu_add | output | 1 | Select ALU add |
| ir_offs_out | output | 1 | Drive instruction offset/address field onto the bus |
| rf_out | output | 1 | Drive the addressed general register onto the bus |
| rf_in | output | 1 | Load the addressed general register |
| mem_rd | output | 1 | Memory read request |
| end_op | output | 1 | Instruction complete; next slot is a fetch |
| step | output | STEP_W | Current step count |

## Verification
The assertions assume that `ir_opcode` is stable from step 3 until the end slot, because the instruction register is not reloaded mid-instruction. They also assume that `mem_done` is a clean, synchronous level. The bench changes the opcode only in step 0. It toggles `flag_n` in every step except 3, so that a late flag change is shown to be ignored. It raises `mem_done` outside wait steps, so that those steps are shown to be unaffected by it. The bench sweeps every opcode value, both flag values and three memory latencies.

// File: rtl/hcu_pkg.sv
package hcu_pkg;

   typedef enum logic [1:0] {
      CLS_NOP = 2'd0,
      CLS_ADD = 2'd1,
      CLS_JMP = 2'd2,
      CLS_BRN = 2'd3
   } icls_e;

   typedef struct packed {
      logic pc_out;
      logic pc_in;
      logic mar_in;
      logic mdr_out;
      logic ir_in;
      logic y_in;
      logic y_clr;
      logic z_in;
      logic z_out;
      logic alu_cin;
      logic alu_add;
      logic offs_out;
      logic rf_out;
      logic rf_in;
      logic mem_rd;
      logic end_op;
   } ctrl_t;

   localparam int FETCH_PC   = 0;
   localparam int FETCH_WAIT = 1;
   localparam int FETCH_IR   = 2;
   localparam int EXEC_FIRST = 3;
   localparam int LAST_STEP  = 7;

endpackage

// File: rtl/hcu_opdec.sv
module hcu_opdec #(
   parameter int OPC_W   = 4,
   parameter int OPC_ADD = 1,
   parameter int OPC_JMP = 2,
   parameter int OPC_BRN = 3
) (
   input  logic [OPC_W-1:0] opcode,
   output hcu_pkg::icls_e   cls
);
   import hcu_pkg::*;

   localparam int NCODE = 3;
   localparam int CODES [NCODE] = '{OPC_ADD, OPC_JMP, OPC_BRN};

   if (OPC_W < 2 || OPC_W > 16) begin : g_bad_width
      $error("hcu_opdec: OPC_W out of range");
   end
   for (genvar k = 0; k < NCODE; k++) begin : g_chk
      if (CODES[k] < 0 || CODES[k] >= (1 << OPC_W)) begin : g_bad_code
         $error("hcu_opdec: opcode does not fit field");
      end
      for (genvar j = k + 1; j < NCODE; j++) begin : g_dup
         if (CODES[k] == CODES[j]) begin : g_same
            $error("hcu_opdec: opcodes must be distinct");
         end
      end
   end

   logic [NCODE-1:0] hit;
   for (genvar k = 0; k < NCODE; k++) begin : g_match
      assign hit[k] = (opcode == OPC_W'(CODES[k]));
   end

   always_comb begin
      cls = CLS_NOP;
      if (hit[0])      cls = CLS_ADD;
      else if (hit[1]) cls = CLS_JMP;
      else if (hit[2]) cls = CLS_BRN;
   end

endmodule

// File: rtl/hcu_sigtab.sv
module hcu_sigtab #(
   parameter int STEP_W = 3
) (
   input  logic [STEP_W-1:0] step,
   input  logic              first,
   input  hcu_pkg::icls_e    cls,
   input  logic              flag_n,
   output hcu_pkg::ctrl_t    ctrl,
   output logic              wait_mfc
);
   import hcu_pkg::*;

   if (STEP_W < 3) begin : g_bad_step
      $error("hcu_sigtab: STEP_W must hold eight steps");
   end

   always_comb begin
      ctrl     = '0;
      wait_mfc = 1'b0;
      if (step == STEP_W'(FETCH_PC)) begin
         ctrl.pc_out  = 1'b1;
         ctrl.mar_in  = 1'b1;
         ctrl.mem_rd  = 1'b1;
         ctrl.y_clr   = 1'b1;
         ctrl.alu_cin = 1'b1;
         ctrl.alu_add = 1'b1;
         ctrl.z_in    = 1'b1;
      end else if (step == STEP_W'(FETCH_WAIT)) begin
         wait_mfc   = 1'b1;
         ctrl.z_out = first;
         ctrl.pc_in = first;
      end else if (step == STEP_W'(FETCH_IR)) begin
         ctrl.mdr_out = 1'b1;
         ctrl.ir_in   = 1'b1;
      end else if (step == STEP_W'(EXEC_FIRST)) begin
         unique case (cls)
            CLS_ADD: begin
               ctrl.offs_out = 1'b1;
               ctrl.mar_in   = 1'b1;
               ctrl.mem_rd   = 1'b1;
            end
            CLS_JMP: begin
               ctrl.pc_out = 1'b1;
               ctrl.y_in   = 1'b1;
            end
            CLS_BRN: begin
               ctrl.pc_out = flag_n;
               ctrl.y_in   = flag_n;
               ctrl.end_op = ~flag_n;
            end
            default: ctrl.end_op = 1'b1;
         endcase
      end else if (step == STEP_W'(EXEC_FIRST + 1)) begin
         unique case (cls)
            CLS_ADD: begin
               wait_mfc    = 1'b1;
               ctrl.rf_out = first;
               ctrl.y_in   = first;
            end
            CLS_JMP, CLS_BRN: begin
               ctrl.offs_out = 1'b1;
               ctrl.alu_add  = 1'b1;
               ctrl.z_in     = 1'b1;
            end
            default: ctrl.end_op = 1'b1;
         endcase
      end else if (step == STEP_W'(EXEC_FIRST + 2)) begin
         unique case (cls)
            CLS_ADD: begin
               ctrl.mdr_out = 1'b1;
               ctrl.alu_add = 1'b1;
               ctrl.z_in    = 1'b1;
            end
            CLS_JMP, CLS_BRN: begin
               ctrl.z_out = 1'b1;
               ctrl.pc_in = 1'b1;
            end
            default: ctrl.end_op = 1'b1;
         endcase
      end else if (step == STEP_W'(EXEC_FIRST + 3) && cls == CLS_ADD) begin
         ctrl.z_out = 1'b1;
         ctrl.rf_in = 1'b1;
      end else begin
         ctrl.end_op = 1'b1;
      end
   end

endmodule

// File: rtl/hcu_stepctr.sv
module hcu_stepctr #(
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wait_mfc,
   input  logic              mem_done,
   input  logic              end_op,
   output logic [STEP_W-1:0] step_q,
   output logic              first_q
);
   logic stall;
   assign stall = wait_mfc & ~mem_done & ~end_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= '0;
         first_q <= 1'b1;
      end else begin
         first_q <= ~stall;
         if (end_op)      step_q <= '0;
         else if (!stall) step_q <= step_q + 1'b1;
      end
   end

   assert_end_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      end_op |=> (step_q == '0 && first_q));

   assert_wait_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_mfc && !mem_done && !end_op) |=> ($stable(step_q) && !first_q));

   assert_step_advance_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!end_op && !(wait_mfc && !mem_done)) |=> (step_q == $past(step_q) + 1'b1));

endmodule

// File: rtl/hcu_ctrl_unit.sv
module hcu_ctrl_unit #(
   parameter int OPC_W   = 4,
   parameter int STEP_W  = 3,
   parameter int OPC_ADD = 1,
   parameter int OPC_JMP = 2,
   parameter int OPC_BRN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  ir_opcode,
   input  logic              flag_n,
   input  logic              mem_done,
   output logic              pc_out,
   output logic              pc_in,
   output logic              mar_in,
   output logic              mdr_out,
   output logic              ir_in,
   output logic              y_in,
   output logic              y_clr,
   output logic              z_in,
   output logic              z_out,
   output logic              alu_cin,
   output logic              alu_add,
   output logic              ir_offs_out,
   output logic              rf_out,
   output logic              rf_in,
   output logic              mem_rd,
   output logic              end_op,
   output logic [STEP_W-1:0] step
);
   import hcu_pkg::*;

   icls_e             cls;
   ctrl_t             ctrl;
   logic              wait_mfc;
   logic              first;
   logic [STEP_W-1:0] step_q;

   hcu_opdec #(
      .OPC_W(OPC_W), .OPC_ADD(OPC_ADD), .OPC_JMP(OPC_JMP), .OPC_BRN(OPC_BRN)
   ) u_dec (
      .opcode (ir_opcode),
      .cls    (cls)
   );

   hcu_sigtab #(.STEP_W(STEP_W)) u_tab (
      .step     (step_q),
      .first    (first),
      .cls      (cls),
      .flag_n   (flag_n),
      .ctrl     (ctrl),
      .wait_mfc (wait_mfc)
   );

   hcu_stepctr #(.STEP_W(STEP_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wait_mfc (wait_mfc),
      .mem_done (mem_done),
      .end_op   (ctrl.end_op),
      .step_q   (step_q),
      .first_q  (first)
   );

   assign pc_out      = ctrl.pc_out;
   assign pc_in       = ctrl.pc_in;
   assign mar_in      = ctrl.mar_in;
   assign mdr_out     = ctrl.mdr_out;
   assign ir_in       = ctrl.ir_in;
   assign y_in        = ctrl.y_in;
   assign y_clr       = ctrl.y_clr;
   assign z_in        = ctrl.z_in;
   assign z_out       = ctrl.z_out;
   assign alu_cin     = ctrl.alu_cin;
   assign alu_add     = ctrl.alu_add;
   assign ir_offs_out = ctrl.offs_out;
   assign rf_out      = ctrl.rf_out;
   assign rf_in       = ctrl.rf_in;
   assign mem_rd      = ctrl.mem_rd;
   assign end_op      = ctrl.end_op;
   assign step        = step_q;

   assert_one_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pc_out, z_out, mdr_out, ir_offs_out, rf_out}));

   assert_read_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> mar_in);

endmodule

// File: tb/hcu_ctrl_unit_tb.sv
`timescale 1ns/1ps
module hcu_ctrl_unit_tb;
   localparam int OPC_W  = 4;
   localparam int STEP_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [OPC_W-1:0] ir_opcode = '0;
   logic flag_n = 1'b0;
   logic mem_done = 1'b0;
   logic pc_out, pc_in, mar_in, mdr_out, ir_in, y_in, y_clr, z_in, z_out;
   logic alu_cin, alu_add, ir_offs_out, rf_out, rf_in, mem_rd, end_op;
   logic [STEP_W-1:0] step;

   int nvec = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   hcu_ctrl_unit #(.OPC_W(OPC_W), .STEP_W(STEP_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .flag_n(flag_n),
      .mem_done(mem_done), .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in),
      .mdr_out(mdr_out), .ir_in(ir_in), .y_in(y_in), .y_clr(y_clr),
      .z_in(z_in), .z_out(z_out), .alu_cin(alu_cin), .alu_add(alu_add),
      .ir_offs_out(ir_offs_out), .rf_out(rf_out), .rf_in(rf_in),
      .mem_rd(mem_rd), .end_op(end_op), .step(step)
   );

   // Bit order of a control vector, MSB first:
   // pc_out pc_in mar_in mdr_out ir_in y_in y_clr z_in z_out alu_cin alu_add
   // ir_offs_out rf_out rf_in mem_rd end_op
   localparam logic [15:0] B_PCO = 16'h8000, B_PCI = 16'h4000, B_MAR = 16'h2000,
                           B_MDO = 16'h1000, B_IRI = 16'h0800, B_YI  = 16'h0400,
                           B_YC  = 16'h0200, B_ZI  = 16'h0100, B_ZO  = 16'h0080,
                           B_CI  = 16'h0040, B_ADD = 16'h0020, B_OFO = 16'h0010,
                           B_RFO = 16'h0008, B_RFI = 16'h0004, B_RD  = 16'h0002,
                           B_END = 16'h0001;

   function automatic logic [15:0] actual_vec();
      return {pc_out, pc_in, mar_in, mdr_out, ir_in, y_in, y_clr, z_in, z_out,
              alu_cin, alu_add, ir_offs_out, rf_out, rf_in, mem_rd, end_op};
   endfunction

   // class: 0 unrecognised, 1 add, 2 jump, 3 branch-on-negative (R4)
   function automatic logic [15:0] expect_vec(int st, int cls, bit n, bit fst);
      case (st)
         0: return B_PCO | B_MAR | B_RD | B_YC | B_CI | B_ADD | B_ZI;   // R1
         1: return fst ? (B_ZO | B_PCI) : 16'h0;                       // R2
         2: return B_MDO | B_IRI;                                       // R3
         3: case (cls)
               1: return B_OFO | B_MAR | B_RD;                          // R5
               2: return B_PCO | B_YI;                                  // R6
               3: return n ? (B_PCO | B_YI) : B_END;                    // R7
               default: return B_END;                                   // R8
            endcase
         4: if (cls == 1) return fst ? (B_RFO | B_YI) : 16'h0;
            else return B_OFO | B_ADD | B_ZI;
         5: if (cls == 1) return B_MDO | B_ADD | B_ZI;
            else return B_ZO | B_PCI;
         6: if (cls == 1) return B_ZO | B_RFI;
            else return B_END;
         default: return B_END;
      endcase
   endfunction

   function automatic string tag_of(int st, int cls, bit after_end);
      if (st == 0) return after_end ? "R9 R1" : "R1";
      if (st == 1) return "R2";
      if (st == 2) return "R3";
      case (cls)
         1: return "R5 R4";
         2: return "R6 R4";
         3: return "R7 R4";
         default: return "R8 R4";
      endcase
   endfunction

   task automatic check_vec(string tag, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      int st = 0;
      bit fst = 1'b1;
      int wcnt = 0;
      bit after_end = 1'b0;
      // reset state, R1
      repeat (3) begin
         @(negedge clk);
         #1 check_vec("R1 reset step", 32'(step), 32'd0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      for (int op = 0; op < (1 << OPC_W); op++) begin
         for (int n = 0; n < 2; n++) begin
            for (int li = 0; li < 3; li++) begin
               int lat = (li == 2) ? 3 : li;
               int cls = (op >= 1 && op <= 3) ? op : 0;
               bit done = 1'b0;
               while (!done) begin
                  bit wstep;
                  logic [15:0] ev;
                  logic [15:0] av;
                  if (st == 0) ir_opcode = OPC_W'(op);   // changed only in fetch
                  wstep = (st == 1) || (st == 4 && cls == 1);
                  // R12: mem_done outside wait steps must not matter
                  mem_done = wstep ? (wcnt >= lat) : li[0];
                  // R7: flag only matters in step 3; flip it elsewhere
                  flag_n = (st == 3) ? n[0] : ~n[0];
                  #1;
                  ev = expect_vec(st, cls, n[0], fst);
                  av = actual_vec();
                  check_vec(tag_of(st, cls, after_end), 32'(av), 32'(ev));
                  check_vec("R12 step", 32'(step), 32'(st));
                  check_vec("R10 bus drivers",
                            32'($countones({pc_out, z_out, mdr_out, ir_offs_out, rf_out}) <= 1),
                            32'd1);
                  check_vec("R11 read with address", 32'(mem_rd & ~mar_in), 32'd0);
                  after_end = ev[0];
                  if (ev[0]) begin
                     st = 0; fst = 1'b1; wcnt = 0; done = 1'b1;
                  end else if (wstep && !mem_done) begin
                     fst = 1'b0; wcnt++;
                  end else begin
                     st++; fst = 1'b1; wcnt = 0;
                  end
                  @(negedge clk);
               end
            end
         end
      end
      summary();
      $finish;
   end

endmodule